// File: doc/BRIEF.md
# Capacitor Mismatch Calibration Controller

This block is the digital side of a self-calibration scheme for the upper, binary-weighted capacitors of a charge-redistribution converter. Each of those capacitors has its own small trim DAC. When a calibration is triggered, the block works through the capacitors one at a time, starting with the heaviest. For each one it sums a fixed, power-of-two number of signed error readings taken from an external measurement path. It then divides the sum by shifting it and clamps the result into a 6-bit signed code. The codes are kept in flip-flops and stay valid until the next calibration.

During normal conversions the successive-approximation logic supplies the upper bits of its current trial word. For each calibrated capacitor whose trial bit is 1, the block drives that capacitor's stored code onto its trim output. When the bit is 0, the output is zero. The lower capacitors are not corrected and their bits are not routed here.

A calibration starts on an explicit request or when the supply-good indication rises. While it runs, `busy` tells the conversion logic to wait. All trim outputs stay at zero while `busy` is high and until the first calibration has finished. The analog error measurement itself lies outside the block.

Top module: `msb_cal_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `cal_sel` is 0 and every `corr` field is 0 for any `trial_msb`.
- R2: A one-cycle `cal_req`, or a 0-to-1 change of `pwr_ok`, makes `busy` 1 and `cal_sel` equal to 1 (slot 0) from the next cycle on.
- R3: Slots are measured in order 0, 1, ... NCAL-1. Slot 0 is the heaviest capacitor. While slot k is measured, `cal_sel` is one-hot with bit k set. The block moves to the next slot after exactly 2^TRIAL_LOG2 cycles in which `err_vld` was 1.
- R4: A slot's code is floor(sum of its accepted samples / 2^TRIAL_LOG2), with `err_smp` read as two's complement. The result is clamped to [-2^(CODE_W-1), 2^(CODE_W-1)-1] and stored as a CODE_W-bit two's-complement value.
- R5: On the clock edge that accepts the last sample of the last slot, `busy` falls and `done` rises. `done` stays high for exactly one cycle.
- R6: When the block is not busy and at least one calibration has completed, field k of `corr` (bits k*CODE_W +: CODE_W) equals slot k's code if `trial_msb[NCAL-1-k]` is 1. Otherwise the field is 0. The fields follow `trial_msb` in the same cycle.
- R7: While `busy` is 1, or before any calibration has completed, all of `corr` is 0.
- R8: A trigger that arrives while `busy` is 1 discards all partial sums and restarts at slot 0. Any sample offered in that cycle is dropped. The codes produced afterwards depend only on samples accepted after the restart.
- R9: While the block is not busy, `err_vld` and `err_smp` have no effect. The stored codes keep their values indefinitely until the next calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibration request |
| pwr_ok | input | 1 | Supply-good level; its rising edge triggers calibration |
| err_vld | input | 1 | Error sample present this cycle |
| err_smp | input | ERR_W | Signed error sample for the selected capacitor |
| trial_msb | input | NCAL | Upper bits of the current trial word; bit NCAL-1 is the heaviest |
| cal_sel | output | NCAL | One-hot marker of the capacitor under measurement |
| corr | output | NCAL*CODE_W | Trim codes, one CODE_W field per capacitor |
| busy | output | 1 | Calibration in progress; conversions must wait |
| done | output | 1 | One-cycle pulse when calibration finishes |

## Verification
The calibrations are run with different per-capacitor mean errors and random noise, and with gaps in `err_vld`. This shows that the sample count and slot order follow accepted samples rather than cycles. Noise sums that are not multiples of the trial count show whether rounding is floor rather than truncation toward zero. Large positive and negative means separate correct clamping from wrap-around. A restart mid-way through slot 1 shows that partial sums are discarded. Random trial words applied after completion, and floods of idle samples, show that the gating is per bit and that stored codes do not drift.

// File: rtl/msb_cal_engine.sv
module msb_cal_engine #(
  parameter int NCAL       = 4,
  parameter int CODE_W     = 6,
  parameter int ERR_W      = 8,
  parameter int TRIAL_LOG2 = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_req,
  input  logic                   pwr_ok,
  input  logic                   err_vld,
  input  logic [ERR_W-1:0]       err_smp,
  input  logic [NCAL-1:0]        trial_msb,
  output logic [NCAL-1:0]        cal_sel,
  output logic [NCAL*CODE_W-1:0] corr,
  output logic                   busy,
  output logic                   done
);
  localparam int IW    = (NCAL > 1) ? $clog2(NCAL) : 1;
  localparam int ACC_W = ERR_W + TRIAL_LOG2 + 1;
  localparam logic signed [ACC_W-1:0] CMAX = ACC_W'((1 << (CODE_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] CMIN = -CMAX - 1;

  logic                          pwr_q, cal_ok;
  logic [IW-1:0]                 idx;
  logic [TRIAL_LOG2-1:0]         cnt;
  logic signed [ACC_W-1:0]       acc, acc_nx, avg;
  logic [CODE_W-1:0]             sat;
  logic [NCAL-1:0][CODE_W-1:0]   codes;

  wire start = cal_req | (pwr_ok & ~pwr_q);
  wire take  = busy & err_vld & ~start;
  wire last  = &cnt;

  assign acc_nx  = acc + ACC_W'($signed(err_smp));
  assign avg     = acc_nx >>> TRIAL_LOG2;
  assign cal_sel = busy ? (NCAL'(1) << idx) : '0;

  always_comb begin
    if (avg > CMAX)      sat = CMAX[CODE_W-1:0];
    else if (avg < CMIN) sat = CMIN[CODE_W-1:0];
    else                 sat = avg[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      cal_ok <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      acc    <= '0;
      codes  <= '0;
    end else begin
      pwr_q <= pwr_ok;
      done  <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        cnt  <= '0;
        acc  <= '0;
      end else if (take) begin
        if (last) begin
          codes[idx] <= sat;
          acc        <= '0;
          cnt        <= '0;
          if (idx == IW'(NCAL-1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            cal_ok <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          acc <= acc_nx;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < NCAL; k++) begin : g_trim
    wire hit = trial_msb[NCAL-1-k] & cal_ok & ~busy;
    assign corr[k*CODE_W +: CODE_W] = hit ? codes[k] : '0;
  end

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cal_sel == NCAL'(1)));
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(cal_sel));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  corr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (corr == '0));
  // R9
  codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(codes));
endmodule

// File: tb/msb_cal_engine_tb_top.sv
module msb_cal_engine_tb_top;
  localparam int NCAL = 4, CODE_W = 6, ERR_W = 8, TL = 5;
  localparam int TRIALS = 1 << TL;

  logic clk = 0, rst_n = 0, cal_req = 0, pwr_ok = 0, err_vld = 0;
  logic [ERR_W-1:0] err_smp = '0;
  logic [NCAL-1:0] trial_msb = '0, cal_sel;
  logic [NCAL*CODE_W-1:0] corr;
  logic busy, done;

  int total = 0, fails = 0;
  int exp_code[NCAL];
  bit cal_valid = 0, finished = 0;

  always #10 clk = ~clk;

  msb_cal_engine #(.NCAL(NCAL), .CODE_W(CODE_W), .ERR_W(ERR_W), .TRIAL_LOG2(TL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .pwr_ok(pwr_ok), .err_vld(err_vld),
    .err_smp(err_smp), .trial_msb(trial_msb), .cal_sel(cal_sel), .corr(corr),
    .busy(busy), .done(done));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sat_avg(int sum);
    int q = sum >>> TL;
    if (q > 31) q = 31;
    if (q < -32) q = -32;
    return q;
  endfunction

  function automatic logic [NCAL*CODE_W-1:0] expect_corr(logic [NCAL-1:0] tm);
    logic [NCAL*CODE_W-1:0] v = '0;
    for (int k = 0; k < NCAL; k++)
      if (cal_valid && tm[NCAL-1-k]) v[k*CODE_W +: CODE_W] = CODE_W'(exp_code[k]);
    return v;
  endfunction

  task automatic apply_checks(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trial_msb = NCAL'($urandom);
      #1;
      check(corr == expect_corr(trial_msb), req, "corr", longint'(corr),
            longint'(expect_corr(trial_msb)));
    end
  endtask

  task automatic run_cal(bit use_pwr, int mean[NCAL], int noise, int restart_at);
    int k = 0, cnt = 0, sum = 0, n = 0, smp;
    bit newslot = 1, restarted = 0, vld;
    @(negedge clk);
    err_vld = 0;
    if (use_pwr) pwr_ok = 1; else cal_req = 1;
    while (k < NCAL) begin
      @(negedge clk);
      cal_req = 0;
      if (newslot) begin
        check(busy == 1'b1, restarted ? "R8" : "R2", "busy", busy, 1);
        check(cal_sel == NCAL'(1 << k), restarted && k == 0 ? "R8" : "R3", "cal_sel",
              cal_sel, 1 << k);
        trial_msb = NCAL'($urandom);
        #1;
        check(corr == '0, "R7", "corr while busy", longint'(corr), 0);
        newslot = 0;
      end
      smp = mean[k] + int'($urandom_range(2 * noise, 0)) - noise;
      err_smp = ERR_W'(smp);
      if (restart_at >= 0 && n == restart_at && !restarted) begin
        cal_req = 1; err_vld = 1; restarted = 1;
        k = 0; cnt = 0; sum = 0; newslot = 1; n++;
      end else begin
        vld = ($urandom % 4) != 0;
        err_vld = vld;
        if (vld) begin
          sum += smp; cnt++; n++;
          if (cnt == TRIALS) begin
            exp_code[k] = sat_avg(sum);
            k++; cnt = 0; sum = 0; newslot = 1;
          end
        end
      end
    end
    @(negedge clk);
    err_vld = 0;
    check(busy == 1'b0, "R5", "busy at end", busy, 0);
    check(done == 1'b1, "R5", "done pulse", done, 1);
    cal_valid = 1;
    @(negedge clk);
    check(done == 1'b0, "R5", "done width", done, 0);
  endtask

  initial begin
    int m[NCAL];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    trial_msb = '1;
    #1;
    check(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
    check(cal_sel == '0, "R1", "cal_sel", cal_sel, 0);
    check(corr == '0, "R1", "corr", longint'(corr), 0);
    apply_checks(4, "R7");

    m = '{3, -5, 10, -1};
    run_cal(1'b1, m, 8, -1);
    apply_checks(16, "R6");
    apply_checks(2, "R4");

    m = '{100, -100, 0, 31};
    run_cal(1'b0, m, 20, -1);
    check(exp_code[0] == 31 && exp_code[1] == -32, "R4", "bench clamp", exp_code[0], 31);
    apply_checks(16, "R4");

    m = '{-7, 12, -2, 5};
    run_cal(1'b0, m, 15, 50);
    apply_checks(16, "R8");

    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      err_vld = 1;
      err_smp = (i % 2) ? 8'h7f : 8'h80;
    end
    @(negedge clk);
    err_vld = 0;
    repeat (500) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after idle samples", busy, 0);
    apply_checks(16, "R9");

    m = '{0, -1, 1, -3};
    run_cal(1'b0, m, 3, -1);
    apply_checks(16, "R6");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule